// File: doc/BRIEF.md
# Two-Tap Adaptive Channel-Mismatch Estimator

This block works in the background of a two-channel interleaved converter. Each of its two inputs carries only the extracted calibration tone of one channel. A two-coefficient linear predictor learns how the second channel's tone follows from the first channel's current and previous samples. The coefficients adapt with a least-mean-squares step whose size a shift input sets. Because a predictor that maps one tone onto the other encodes the relative gain and sampling skew of the two channels, the block then turns the learned pair into a gain-error figure and a timing-error figure. It does this with a linear, small-error mapping built from two programmable offsets and two programmable scale factors.

The coefficients are updated once per valid sample pair, and an update strobe marks each new pair. The two error figures are recomputed once per window of accepted samples and are flagged by their own one-cycle strobe. Applying any correction to the sample stream is left to other logic.

Top module: `mmest_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both coefficients load `cst_a >>> 1` (arithmetic shift, so -3 loads -2), the stored previous sample clears to 0, the window counter clears, both strobes go low and both error outputs go to 0.
- R2: A cycle with `smp_valid` low leaves both coefficients and the stored previous sample unchanged.
- R3: `coef_strobe` is high in exactly those cycles that follow a cycle with `smp_valid` high, and `h0_out`/`h1_out` carry the coefficients updated from that sample in the same cycle.
- R4: For a sample pair (x0, x1) with previous accepted first-channel sample xp, the prediction is y = (h0*x0 + h1*xp) >>> 16 and the error is e = x1 - y. The new coefficients are h0 + ((e*x0) >>> (13+mu_shift)) and h1 + ((e*xp) >>> (13+mu_shift)). All values are signed, coefficients are 20-bit with 16 fraction bits, and the samples are 16-bit.
- R5: A coefficient update that leaves the 20-bit signed range is clamped to 524287 or -524288 instead of wrapping.
- R6: xp is the first-channel sample of the most recent earlier cycle with `smp_valid` high, no matter how many idle cycles lie between.
- R7: After every 256th accepted sample since reset, `est_strobe` is high for exactly one cycle, one cycle after the `coef_strobe` of that sample. The error outputs change only in such a cycle.
- R8: At that point `gain_err` = ((h0 + h1 - cst_a) * k_gain) >>> 12, using the coefficients from the 256th update. `k_gain` is signed with 12 fraction bits.
- R9: At that point `time_err` = ((h0 - h1 - cst_b) * k_time) >>> 12, with the same coefficients. `k_time` is signed with 12 fraction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample pair present this cycle |
| x0_in | input | 16 | First-channel tone sample, signed |
| x1_in | input | 16 | Second-channel tone sample, signed |
| mu_shift | input | 5 | Extra right shift of the adaptation step |
| cst_a | input | 20 | Gain offset constant, also the coefficient seed, signed Q4.16 |
| cst_b | input | 20 | Timing offset constant, signed Q4.16 |
| k_gain | input | 16 | Gain scale factor, signed Q4.12 |
| k_time | input | 16 | Timing scale factor, signed Q4.12 |
| h0_out | output | 20 | Current-sample coefficient, signed Q4.16 |
| h1_out | output | 20 | Previous-sample coefficient, signed Q4.16 |
| coef_strobe | output | 1 | Coefficients just updated |
| gain_err | output | 26 | Gain mismatch estimate, signed |
| time_err | output | 26 | Timing mismatch estimate, signed |
| est_strobe | output | 1 | Error estimates just refreshed |

## Verification
A corrupted coefficient or a wrong stored previous sample shows on `h0_out`/`h1_out` at the very next `coef_strobe`. The scoreboard compares every update, so a fault appears within one accepted sample. A fault that only shifts the delay line across idle cycles appears in the first update after a gap. A wrong window count or a wrong inversion term cannot show before the 256th sample, when `est_strobe` comes early, comes late, or carries a value that differs from the one rebuilt from the last predicted coefficients. Clamping faults show only once the step is driven to divergence, so a dedicated unstable-step phase checks the rail values.

// File: rtl/mmest_pkg.sv
`timescale 1ns/1ps
package mmest_pkg;
    // Default geometry shared by the estimator sub-blocks
    localparam int unsigned MM_X_W      = 16;  // tone sample width
    localparam int unsigned MM_H_W      = 20;  // coefficient width
    localparam int unsigned MM_H_FRAC   = 16;  // coefficient fraction bits
    localparam int unsigned MM_MU_W     = 5;   // step shift width
    localparam int unsigned MM_K_W      = 16;  // inversion scale width
    localparam int unsigned MM_K_FRAC   = 12;  // inversion scale fraction bits
    localparam int unsigned MM_WIN_LOG2 = 8;   // log2 of estimate window

    typedef logic signed [MM_H_W-1:0] mm_coef_t;
endpackage

// File: rtl/mmest_lms_core.sv
`timescale 1ns/1ps
module mmest_lms_core #(
    parameter int unsigned X_W    = 16,
    parameter int unsigned H_W    = 20,
    parameter int unsigned H_FRAC = 16,
    parameter int unsigned MU_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic signed [X_W-1:0] x0_in,
    input  logic signed [X_W-1:0] x1_in,
    input  logic [MU_W-1:0]       mu_shift,
    input  logic signed [H_W-1:0] cst_a,
    output logic signed [H_W-1:0] h0_out,
    output logic signed [H_W-1:0] h1_out,
    output logic                  coef_strobe
);
    localparam int X_FRAC  = X_W - 1;
    localparam int SUM_W   = H_W + X_W + 1;
    localparam int Y_W     = SUM_W - H_FRAC;
    localparam int E_W     = Y_W + 1;
    localparam int P_W     = E_W + X_W;
    localparam int ACC_W   = P_W + 1;
    localparam int BASE_SH = 2 * X_FRAC - H_FRAC - 1;
    localparam logic signed [ACC_W-1:0] H_MAX = ACC_W'((64'sd1 <<< (H_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] H_MIN = -H_MAX - ACC_W'(1);

    typedef struct packed {
        logic signed [H_W-1:0] h0;
        logic signed [H_W-1:0] h1;
        logic signed [X_W-1:0] xp;
        logic                  stb;
    } lms_st_t;

    lms_st_t st_q, st_d, st_rst;

    logic signed [H_W-1:0]   h_cur [2];
    logic signed [X_W-1:0]   tap_x [2];
    logic signed [H_W-1:0]   h_upd [2];
    logic signed [SUM_W-1:0] pred_sum;
    logic signed [Y_W-1:0]   pred_y;
    logic signed [E_W-1:0]   pred_err;

    always_comb begin
        h_cur[0] = st_q.h0;
        h_cur[1] = st_q.h1;
        tap_x[0] = x0_in;
        tap_x[1] = st_q.xp;
    end

    // prediction of the second channel from the two first-channel taps
    always_comb begin
        pred_sum = SUM_W'(h_cur[0]) * SUM_W'(tap_x[0])
                 + SUM_W'(h_cur[1]) * SUM_W'(tap_x[1]);
        pred_y   = Y_W'(pred_sum >>> H_FRAC);
        pred_err = E_W'(x1_in) - E_W'(pred_y);
    end

    // per-tap gradient step with clamping
    generate
        for (genvar t = 0; t < 2; t++) begin : g_tap
            logic signed [P_W-1:0]   corr;
            logic signed [P_W-1:0]   step;
            logic signed [ACC_W-1:0] acc;
            always_comb begin
                corr = P_W'(pred_err) * P_W'(tap_x[t]);
                step = corr >>> (BASE_SH + int'(mu_shift));
                acc  = ACC_W'(h_cur[t]) + ACC_W'(step);
                if (acc > H_MAX) begin
                    h_upd[t] = H_W'(H_MAX);
                end else if (acc < H_MIN) begin
                    h_upd[t] = H_W'(H_MIN);
                end else begin
                    h_upd[t] = H_W'(acc);
                end
            end
        end
    endgenerate

    always_comb begin
        st_rst.h0  = cst_a >>> 1;
        st_rst.h1  = cst_a >>> 1;
        st_rst.xp  = '0;
        st_rst.stb = 1'b0;
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = smp_valid;
        if (smp_valid) begin
            st_d.h0 = h_upd[0];
            st_d.h1 = h_upd[1];
            st_d.xp = x0_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign h0_out      = st_q.h0;
    assign h1_out      = st_q.h1;
    assign coef_strobe = st_q.stb;
endmodule

// File: rtl/mmest_window.sv
`timescale 1ns/1ps
module mmest_window #(
    parameter int unsigned WIN_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    output logic win_tick
);
    typedef struct packed {
        logic [WIN_LOG2-1:0] cnt;
        logic                tick;
    } win_st_t;

    win_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.tick = smp_valid && (&st_q.cnt);
        if (smp_valid) begin
            st_d.cnt = st_q.cnt + WIN_LOG2'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_tick = st_q.tick;
endmodule

// File: rtl/mmest_invert.sv
`timescale 1ns/1ps
module mmest_invert #(
    parameter int unsigned H_W    = 20,
    parameter int unsigned K_W    = 16,
    parameter int unsigned K_FRAC = 12,
    parameter int unsigned EST_W  = H_W + 2 + K_W - K_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic signed [H_W-1:0]   h0,
    input  logic signed [H_W-1:0]   h1,
    input  logic signed [H_W-1:0]   cst_a,
    input  logic signed [H_W-1:0]   cst_b,
    input  logic signed [K_W-1:0]   k_gain,
    input  logic signed [K_W-1:0]   k_time,
    output logic signed [EST_W-1:0] gain_err,
    output logic signed [EST_W-1:0] time_err,
    output logic                    est_strobe
);
    localparam int D_W = H_W + 2;
    localparam int M_W = D_W + K_W;

    typedef struct packed {
        logic signed [EST_W-1:0] g;
        logic signed [EST_W-1:0] tm;
        logic                    stb;
    } inv_st_t;

    inv_st_t st_q, st_d;

    logic signed [D_W-1:0]   dev   [2];
    logic signed [K_W-1:0]   scale [2];
    logic signed [EST_W-1:0] est   [2];

    // linearised small-error mapping: sum term for gain, difference for skew
    always_comb begin
        dev[0]   = D_W'(h0) + D_W'(h1) - D_W'(cst_a);
        dev[1]   = D_W'(h0) - D_W'(h1) - D_W'(cst_b);
        scale[0] = k_gain;
        scale[1] = k_time;
    end

    generate
        for (genvar c = 0; c < 2; c++) begin : g_chan
            logic signed [M_W-1:0] prod;
            always_comb begin
                prod   = M_W'(dev[c]) * M_W'(scale[c]);
                est[c] = EST_W'(prod >>> K_FRAC);
            end
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.stb = fire;
        if (fire) begin
            st_d.g  = est[0];
            st_d.tm = est[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_err   = st_q.g;
    assign time_err   = st_q.tm;
    assign est_strobe = st_q.stb;
endmodule

// File: rtl/mmest_top.sv
`timescale 1ns/1ps
module mmest_top
    import mmest_pkg::*;
#(
    parameter int unsigned X_W      = MM_X_W,
    parameter int unsigned H_W      = MM_H_W,
    parameter int unsigned H_FRAC   = MM_H_FRAC,
    parameter int unsigned MU_W     = MM_MU_W,
    parameter int unsigned K_W      = MM_K_W,
    parameter int unsigned K_FRAC   = MM_K_FRAC,
    parameter int unsigned WIN_LOG2 = MM_WIN_LOG2,
    localparam int unsigned EST_W   = H_W + 2 + K_W - K_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [X_W-1:0]   x0_in,
    input  logic signed [X_W-1:0]   x1_in,
    input  logic [MU_W-1:0]         mu_shift,
    input  logic signed [H_W-1:0]   cst_a,
    input  logic signed [H_W-1:0]   cst_b,
    input  logic signed [K_W-1:0]   k_gain,
    input  logic signed [K_W-1:0]   k_time,
    output logic signed [H_W-1:0]   h0_out,
    output logic signed [H_W-1:0]   h1_out,
    output logic                    coef_strobe,
    output logic signed [EST_W-1:0] gain_err,
    output logic signed [EST_W-1:0] time_err,
    output logic                    est_strobe
);
    logic win_tick;

    mmest_lms_core #(
        .X_W    (X_W),
        .H_W    (H_W),
        .H_FRAC (H_FRAC),
        .MU_W   (MU_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .x0_in       (x0_in),
        .x1_in       (x1_in),
        .mu_shift    (mu_shift),
        .cst_a       (cst_a),
        .h0_out      (h0_out),
        .h1_out      (h1_out),
        .coef_strobe (coef_strobe)
    );

    mmest_window #(
        .WIN_LOG2 (WIN_LOG2)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .win_tick  (win_tick)
    );

    mmest_invert #(
        .H_W    (H_W),
        .K_W    (K_W),
        .K_FRAC (K_FRAC),
        .EST_W  (EST_W)
    ) u_inv (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (win_tick),
        .h0         (h0_out),
        .h1         (h1_out),
        .cst_a      (cst_a),
        .cst_b      (cst_b),
        .k_gain     (k_gain),
        .k_time     (k_time),
        .gain_err   (gain_err),
        .time_err   (time_err),
        .est_strobe (est_strobe)
    );
endmodule

// File: rtl/mmest_chk.sv
`timescale 1ns/1ps
module mmest_chk #(
    parameter int unsigned H_W   = 20,
    parameter int unsigned EST_W = 26
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic signed [H_W-1:0]   h0_out,
    input logic signed [H_W-1:0]   h1_out,
    input logic                    coef_strobe,
    input logic signed [EST_W-1:0] gain_err,
    input logic signed [EST_W-1:0] time_err,
    input logic                    est_strobe
);
    // R2
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(h0_out) && $stable(h1_out)));

    // R3
    coef_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> coef_strobe);

    // R3
    coef_nostb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !coef_strobe);

    // R7
    est_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        est_strobe |=> !est_strobe);

    // R7
    est_after_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        est_strobe |-> $past(coef_strobe));

    // R7
    est_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !est_strobe |-> ($stable(gain_err) && $stable(time_err)));
endmodule

bind mmest_top mmest_chk #(
    .H_W   (H_W),
    .EST_W (EST_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .h0_out      (h0_out),
    .h1_out      (h1_out),
    .coef_strobe (coef_strobe),
    .gain_err    (gain_err),
    .time_err    (time_err),
    .est_strobe  (est_strobe)
);

// File: tb/mmest_top_tb_top.sv
`timescale 1ns/1ps
module mmest_top_tb_top;
    localparam int X_W   = 16;
    localparam int H_W   = 20;
    localparam int K_W   = 16;
    localparam int EST_W = 26;
    localparam longint HMAX = 524287;
    localparam longint HMIN = -524288;

    typedef struct { longint h0; longint h1; bit win_end; } coef_exp_t;
    typedef struct { longint g; longint t; } est_exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_valid = 1'b0;
    logic signed [X_W-1:0]   x0_in = '0;
    logic signed [X_W-1:0]   x1_in = '0;
    logic [4:0]              mu_shift = '0;
    logic signed [H_W-1:0]   cst_a = '0;
    logic signed [H_W-1:0]   cst_b = '0;
    logic signed [K_W-1:0]   k_gain = '0;
    logic signed [K_W-1:0]   k_time = '0;
    logic signed [H_W-1:0]   h0_out;
    logic signed [H_W-1:0]   h1_out;
    logic                    coef_strobe;
    logic signed [EST_W-1:0] gain_err;
    logic signed [EST_W-1:0] time_err;
    logic                    est_strobe;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // reference model state
    longint m_h0, m_h1, m_xp, m_a, m_b, m_kg, m_kt;
    int     m_mu, m_cnt, sat_hits;
    coef_exp_t coef_q[$];
    est_exp_t  est_q[$];

    // monitor state
    bit     mon_en = 1'b0;
    longint seen_h0, seen_h1;
    longint cyc = 0, est_due = -1;

    always #10 clk = ~clk;

    mmest_top dut_i (
        .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid),
        .x0_in (x0_in), .x1_in (x1_in), .mu_shift (mu_shift),
        .cst_a (cst_a), .cst_b (cst_b), .k_gain (k_gain), .k_time (k_time),
        .h0_out (h0_out), .h1_out (h1_out), .coef_strobe (coef_strobe),
        .gain_err (gain_err), .time_err (time_err), .est_strobe (est_strobe)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clamp(input longint v);
        if (v > HMAX) return HMAX;
        if (v < HMIN) return HMIN;
        return v;
    endfunction

    task automatic do_reset(input longint a, input longint b, input longint kg, input longint kt, input int mu);
        @(negedge clk);
        mon_en = 1'b0;
        rst_n = 1'b0; smp_valid = 1'b0;
        cst_a = H_W'(a); cst_b = H_W'(b);
        k_gain = K_W'(kg); k_time = K_W'(kt); mu_shift = 5'(mu);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(longint'(h0_out) == (a >>> 1), "R1 h0 seed", longint'(h0_out), a >>> 1);
        check(longint'(h1_out) == (a >>> 1), "R1 h1 seed", longint'(h1_out), a >>> 1);
        check(!coef_strobe && !est_strobe, "R1 strobes low", longint'({coef_strobe, est_strobe}), 0);
        check(gain_err == '0 && time_err == '0, "R1 estimates zero", longint'(gain_err), 0);
        m_h0 = a >>> 1; m_h1 = a >>> 1; m_xp = 0;
        m_a = a; m_b = b; m_kg = kg; m_kt = kt; m_mu = mu; m_cnt = 0;
        coef_q.delete(); est_q.delete();
        seen_h0 = m_h0; seen_h1 = m_h1; est_due = -1;
        rst_n = 1'b1;
        mon_en = 1'b1;
    endtask

    // driver: applies one sample pair and pushes the predicted results
    task automatic drive(input longint x0, input longint x1);
        longint y, e, s, d0, d1;
        coef_exp_t ce;
        est_exp_t  ee;
        @(negedge clk);
        smp_valid = 1'b1;
        x0_in = X_W'(x0); x1_in = X_W'(x1);
        y  = (m_h0 * x0 + m_h1 * m_xp) >>> 16;
        e  = x1 - y;
        s  = 13 + m_mu;
        d0 = (e * x0) >>> s;
        d1 = (e * m_xp) >>> s;
        m_h0 = clamp(m_h0 + d0);
        m_h1 = clamp(m_h1 + d1);
        m_xp = x0;
        m_cnt++;
        ce.h0 = m_h0; ce.h1 = m_h1; ce.win_end = (m_cnt % 256 == 0);
        coef_q.push_back(ce);
        if (ce.win_end) begin
            ee.g = ((m_h0 + m_h1 - m_a) * m_kg) >>> 12;
            ee.t = ((m_h0 - m_h1 - m_b) * m_kt) >>> 12;
            est_q.push_back(ee);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            x0_in = X_W'(16'h5a5a); x1_in = X_W'(16'h7777);
        end
    endtask

    // monitor: compares results as the design produces them
    initial begin
        coef_exp_t ce;
        est_exp_t  ee;
        forever begin
            @(negedge clk);
            cyc++;
            if (mon_en) begin
                if (coef_strobe) begin
                    if (coef_q.size() == 0) begin
                        check(1'b0, "R3 unexpected coef_strobe", 1, 0);
                    end else begin
                        ce = coef_q.pop_front();
                        // R4 R6: coefficient values after update
                        check(longint'(h0_out) == ce.h0, "R4 R6 h0", longint'(h0_out), ce.h0);
                        check(longint'(h1_out) == ce.h1, "R4 R6 h1", longint'(h1_out), ce.h1);
                        if (ce.h0 == HMAX || ce.h0 == HMIN || ce.h1 == HMAX || ce.h1 == HMIN) begin
                            check(longint'(h0_out) == ce.h0 && longint'(h1_out) == ce.h1,
                                  "R5 clamp", longint'(h0_out), ce.h0);
                            sat_hits++;
                        end
                        if (ce.win_end) est_due = cyc + 1;
                        seen_h0 = ce.h0; seen_h1 = ce.h1;
                    end
                end else begin
                    // R2: no sample, no change
                    check(longint'(h0_out) == seen_h0 && longint'(h1_out) == seen_h1,
                          "R2 hold", longint'(h0_out), seen_h0);
                end
                if (est_strobe) begin
                    check(cyc == est_due, "R7 estimate timing", cyc, est_due);
                    if (est_q.size() == 0) begin
                        check(1'b0, "R7 unexpected est_strobe", 1, 0);
                    end else begin
                        ee = est_q.pop_front();
                        check(longint'(gain_err) == ee.g, "R8 gain", longint'(gain_err), ee.g);
                        check(longint'(time_err) == ee.t, "R9 timing", longint'(time_err), ee.t);
                    end
                end else if (cyc == est_due) begin
                    check(1'b0, "R7 missing est_strobe", 0, 1);
                end
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        longint x0, x1, xprev;
        sat_hits = 0;
        // phase 1: moderate step, tone-like data with idle gaps
        do_reset(65536, 1000, 4096, 2048, 6);
        xprev = 0;
        for (int n = 0; n < 300; n++) begin
            x0 = ((longint'(n) * 7919) % 4001 - 2000) * 4;
            x1 = (x0 * 9) / 10 + xprev / 8;
            xprev = x0;
            drive(x0, x1);
            if (n % 5 == 4) idle(2);   // R2 R6: gaps between samples
        end
        // phase 2: larger step, back-to-back samples, crosses second window
        idle(1);
        @(negedge clk);
        mu_shift = 5'd2; m_mu = 2;
        for (int n = 0; n < 230; n++) begin
            x0 = ((longint'(n) * 4513) % 3001 - 1500) * 6;
            x1 = -(x0 * 3) / 4 + 100;
            drive(x0, x1);
        end
        idle(6);
        check(coef_q.size() == 0, "R3 all updates seen", coef_q.size(), 0);
        check(est_q.size() == 0, "R7 both windows seen", est_q.size(), 0);
        // phase 3: odd negative seed, unstable step forces the rails
        do_reset(-3, -7, -4096, 1024, 0);
        for (int n = 0; n < 40; n++) begin
            drive(32767, 0);
        end
        idle(4);
        check(sat_hits > 0, "R5 rails reached", sat_hits, 1);
        check(coef_q.size() == 0, "R3 all updates seen after clamp", coef_q.size(), 0);
        finish_run();
    end
endmodule